// File: doc/BRIEF.md
# Bit-Serial Iterative Rotation CORDIC

This block rotates a two's complement vector (X, Y) by an angle Z with the rotation-mode CORDIC recurrence. It moves all three words one bit per clock, least significant bit first. A single-bit add/subtract cell with its own carry flop sits on each word. The per-iteration right shift never uses a barrel shifter. The partner word sits in a shift-register store, and the shifted operand comes from a fixed read tap `i` positions ahead of the current bit. Once the tap runs past the top bit, the word's sign takes its place. The tap select changes only between word passes, so each clock's logic path is one tap multiplexer plus one full adder.

An operand enters through a valid/ready handshake. The inputs are taken in parallel when `in_valid` and `in_ready` are both high on a rising edge. `in_ready` stays low for the whole computation and there is no input buffering. Any `in_valid` raised while `in_ready` is low is dropped and never stored for later. No iteration can start before the one before it has finished, because the next direction depends on the sign of Z, and that sign is the last bit produced. The total latency is therefore `W*N` clocks. The output side has no back-pressure: `out_done` pulses for one clock, and `out_x`/`out_y` hold the result until the next accepted operand. Gain compensation and quadrant pre-rotation are left to the surrounding logic.

Top module: `cordic_serial_rot`

## Requirements
- R1: After reset `in_ready` is 1, `out_done` is 0 and `out_x`, `out_y` are 0.
- R2: An operand is accepted on a rising edge with `in_valid` and `in_ready` both 1, and `in_ready` is 0 from the next cycle until the cycle in which `out_done` is 1.
- R3: `in_valid` while `in_ready` is 0 is ignored: the running result and its timing are unchanged.
- R4: `out_done` is a single-cycle pulse that goes high exactly `W*N` clock edges after the accepting edge, and `in_ready` is 1 in that same cycle.
- R5: For iterations i = 0..N-1 with d = +1 or -1, the results equal X' = X - d*(Y>>>i) and Y' = Y + d*(X>>>i), computed in W-bit two's complement with wrap-around and arithmetic shifts.
- R6: The direction d is +1 when Z is non-negative (zero included) and -1 otherwise, and Z' = Z - d*A(i).
- R7: Z has W-3 fractional bits (radians), and A(i) = round(atan(2^-i) * 2^(W-3)).
- R8: `out_x` and `out_y` stay constant from `out_done` until the next accepted operand, whatever `in_x`, `in_y`, `in_z` do.
- R9: When the shift reaches past the top bit, a negative partner word contributes -1 (sign extension), not 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Engine idle, operand can be taken |
| in_x | input | W | Start X, two's complement |
| in_y | input | W | Start Y, two's complement |
| in_z | input | W | Angle, W-3 fractional bits |
| out_done | output | 1 | One-cycle pulse when results are final |
| out_x | output | W | Rotated X (unscaled by gain) |
| out_y | output | W | Rotated Y (unscaled by gain) |

## Verification
The bench builds the block with W=16 and N=14. A full run is then 224 clocks, so many complete rotations fit in a short run. With these values the late iterations shift by up to 13, so negative words are sign-extended for most of each pass. With start magnitudes near 12000 and angles up to about ±π/2, the grown vector stays close to the top of the 16-bit range. A real-number arctangent in the bench gives an independent check on the computed constant table, and a second operand offered mid-run checks that the handshake drops it.

// File: rtl/cordic_serial_pkg.sv
package cordic_serial_pkg;

  // arctangent of 2^-i, rounded to frac fractional bits, from a 2^40 scaled
  // power series (pi/4 supplied directly for i = 0)
  function automatic longint atan_q(input int i, input int frac);
    longint acc;
    longint term;
    int     sh;
    acc = 0;
    if (i == 0) begin
      acc = 64'sd863554413092;
    end else begin
      for (int n = 0; n < 21; n++) begin
        sh = i * (2 * n + 1);
        if (sh <= 40) begin
          term = (longint'(1) <<< (40 - sh)) / longint'(2 * n + 1);
          if (n % 2 == 1) acc = acc - term;
          else            acc = acc + term;
        end
      end
    end
    return (acc + (longint'(1) <<< (39 - frac))) >>> (40 - frac);
  endfunction

endpackage

// File: rtl/cordic_serial_addsub.sv
module cordic_serial_addsub (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic first,
  input  logic sub,
  input  logic a,
  input  logic b,
  output logic s
);
  logic carry_q;
  logic cin;
  logic bx;

  // carry seeded with sub at the first bit: a + ~b + 1 for subtraction
  assign cin = first ? sub : carry_q;
  assign bx  = b ^ sub;
  assign s   = a ^ bx ^ cin;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  carry_q <= 1'b0;
    else if (en) carry_q <= (a & bx) | (a & cin) | (bx & cin);
  end
endmodule

// File: rtl/cordic_word_store.sv
module cordic_word_store #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  input  logic         last,
  input  logic         new_bit,
  output logic [W-1:0] word,
  output logic         sign
);
  // new bits enter at the top; after k shifts, word[j] holds old bit j+k
  // for j < W-k, which is what the read tap relies on
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word <= '0;
      sign <= 1'b0;
    end else if (load) begin
      word <= load_val;
      sign <= load_val[W-1];
    end else if (shift) begin
      word <= {new_bit, word[W-1:1]};
      if (last) sign <= new_bit;
    end
  end
endmodule

// File: rtl/cordic_tap_sel.sv
module cordic_tap_sel #(
  parameter int W  = 16,
  parameter int KW = 4,
  parameter int IW = 4
) (
  input  logic [W-1:0]  word,
  input  logic          sign,
  input  logic [KW-1:0] k,
  input  logic [IW-1:0] sh,
  output logic          bit_o
);
  always_comb begin
    if (int'(k) + int'(sh) >= W) bit_o = sign;
    else                         bit_o = word[sh];
  end
endmodule

// File: rtl/cordic_atan_seq.sv
module cordic_atan_seq #(
  parameter int W  = 16,
  parameter int N  = 14,
  parameter int KW = 4,
  parameter int IW = 4
) (
  input  logic [IW-1:0] iter,
  input  logic [KW-1:0] k,
  output logic          bit_o
);
  import cordic_serial_pkg::*;
  localparam int FRAC = W - 3;

  logic [W-1:0] rom [N];

  for (genvar g = 0; g < N; g++) begin : g_rom
    localparam longint AV = atan_q(g, FRAC);
    assign rom[g] = AV[W-1:0];
  end

  assign bit_o = rom[iter][k];
endmodule

// File: rtl/cordic_serial_rot.sv
module cordic_serial_rot #(
  parameter int W = 16,
  parameter int N = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_x,
  input  logic [W-1:0] in_y,
  input  logic [W-1:0] in_z,
  output logic         out_done,
  output logic [W-1:0] out_x,
  output logic [W-1:0] out_y
);
  localparam int KW = $clog2(W);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic          busy;
  logic          done_q;
  logic [KW-1:0] k;
  logic [IW-1:0] iter;
  logic          accept, first, last;

  logic [W-1:0]  x_word, y_word, z_word;
  logic          x_sign, y_sign, z_sign;
  logic          x_tap, y_tap, a_bit;
  logic          x_new, y_new, z_new;

  assign accept   = in_valid & ~busy;
  assign first    = (k == '0);
  assign last     = (k == KW'(W - 1));
  assign in_ready = ~busy;
  assign out_done = done_q;
  assign out_x    = x_word;
  assign out_y    = y_word;

  // iteration control: W clocks per pass, N passes, strictly in sequence
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done_q <= 1'b0;
      k      <= '0;
      iter   <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy <= 1'b1;
        k    <= '0;
        iter <= '0;
      end else if (busy) begin
        if (last) begin
          k <= '0;
          if (iter == IW'(N - 1)) begin
            busy   <= 1'b0;
            done_q <= 1'b1;
          end else begin
            iter <= iter + IW'(1);
          end
        end else begin
          k <= k + KW'(1);
        end
      end
    end
  end

  cordic_word_store #(.W(W)) u_xs (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_val(in_x), .shift(busy),
    .last(last), .new_bit(x_new), .word(x_word), .sign(x_sign));
  cordic_word_store #(.W(W)) u_ys (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_val(in_y), .shift(busy),
    .last(last), .new_bit(y_new), .word(y_word), .sign(y_sign));
  cordic_word_store #(.W(W)) u_zs (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_val(in_z), .shift(busy),
    .last(last), .new_bit(z_new), .word(z_word), .sign(z_sign));

  cordic_tap_sel #(.W(W), .KW(KW), .IW(IW)) u_xtap (
    .word(x_word), .sign(x_sign), .k(k), .sh(iter), .bit_o(x_tap));
  cordic_tap_sel #(.W(W), .KW(KW), .IW(IW)) u_ytap (
    .word(y_word), .sign(y_sign), .k(k), .sh(iter), .bit_o(y_tap));

  cordic_atan_seq #(.W(W), .N(N), .KW(KW), .IW(IW)) u_atan (
    .iter(iter), .k(k), .bit_o(a_bit));

  // z_sign holds the sign of Z for the whole pass; 0 means d = +1
  cordic_serial_addsub u_xadd (
    .clk(clk), .rst_n(rst_n), .en(busy), .first(first), .sub(~z_sign),
    .a(x_word[0]), .b(y_tap), .s(x_new));
  cordic_serial_addsub u_yadd (
    .clk(clk), .rst_n(rst_n), .en(busy), .first(first), .sub(z_sign),
    .a(y_word[0]), .b(x_tap), .s(y_new));
  cordic_serial_addsub u_zadd (
    .clk(clk), .rst_n(rst_n), .en(busy), .first(first), .sub(~z_sign),
    .a(z_word[0]), .b(a_bit), .s(z_new));
endmodule

// File: rtl/cordic_serial_rot_chk.sv
module cordic_serial_rot_chk #(
  parameter int W  = 16,
  parameter int N  = 14,
  parameter int KW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_done,
  input logic [W-1:0]  out_x,
  input logic [W-1:0]  out_y,
  input logic          busy,
  input logic [KW-1:0] k,
  input logic          z_sign,
  input logic [W-1:0]  z_word
);
  int unsigned run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     run_cnt <= 0;
    else if (in_valid && in_ready)  run_cnt <= 0;
    else if (busy)                  run_cnt <= run_cnt + 1;
  end

  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |=> !out_done);

  a_r4_done_latency: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |-> (run_cnt == W * N));

  a_r4_ready_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |-> in_ready);

  a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> ($stable(out_x) && $stable(out_y)));

  a_r6_dir_matches_z: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && k == '0) |-> (z_sign == ($signed(z_word) < 0)));
endmodule

bind cordic_serial_rot cordic_serial_rot_chk #(.W(W), .N(N), .KW(KW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_done(out_done), .out_x(out_x), .out_y(out_y), .busy(busy), .k(k),
  .z_sign(z_sign), .z_word(z_word));

// File: tb/cordic_serial_rot_tb.sv
module cordic_serial_rot_tb;
  localparam int W = 16;
  localparam int N = 14;
  localparam int FRAC = W - 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [W-1:0] in_x = '0, in_y = '0, in_z = '0;
  logic         out_done;
  logic [W-1:0] out_x, out_y;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  cordic_serial_rot #(.W(W), .N(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_x(in_x), .in_y(in_y), .in_z(in_z), .out_done(out_done),
    .out_x(out_x), .out_y(out_y));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, $signed(act), $signed(exp));
    end
  endtask

  // R7: angle constant from real arctangent
  function automatic logic signed [W-1:0] ang(input int i);
    real r;
    r = $atan(1.0 / (2.0 ** i)) * (2.0 ** FRAC);
    return W'($rtoi(r + 0.5));
  endfunction

  // R5, R6, R9: integer recurrence with arithmetic shifts and wrap-around
  task automatic ref_rot(input logic signed [W-1:0] x0, y0, z0,
                         output logic signed [W-1:0] xr, yr);
    logic signed [W-1:0] x, y, z, xs, ys;
    x = x0; y = y0; z = z0;
    for (int i = 0; i < N; i++) begin
      xs = x >>> i;
      ys = y >>> i;
      if (z >= 0) begin
        x = x - ys; y = y + xs; z = z - ang(i);
      end else begin
        x = x + ys; y = y - xs; z = z + ang(i);
      end
    end
    xr = x; yr = y;
  endtask

  task automatic start_op(input logic [W-1:0] x, y, z);
    @(negedge clk);
    in_valid = 1'b1; in_x = x; in_y = y; in_z = z;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    for (int n = 0; n < W * N + 20; n++) begin
      @(negedge clk);
      cyc++;
      if (out_done) break;
    end
  endtask

  task automatic run_and_check(input string tag, input logic [W-1:0] x, y, z);
    logic signed [W-1:0] ex, ey;
    int cyc;
    ref_rot(x, y, z, ex, ey);
    start_op(x, y, z);
    check({tag, " R2 ready low while running"}, 32'(in_ready), 32'd0);
    wait_done(cyc);
    check({tag, " R4 latency"}, cyc, W * N);
    check({tag, " R4 ready with done"}, 32'(in_ready), 32'd1);
    check({tag, " R5 x"}, 32'(signed'(out_x)), 32'(ex));
    check({tag, " R5 y"}, 32'(signed'(out_y)), 32'(ey));
    @(negedge clk);
    check({tag, " R4 done one cycle"}, 32'(out_done), 32'd0);
  endtask

  task automatic t_reset();
    check("R1 ready", 32'(in_ready), 32'd1);
    check("R1 done", 32'(out_done), 32'd0);
    check("R1 out_x", 32'(out_x), 32'd0);
    check("R1 out_y", 32'(out_y), 32'd0);
  endtask

  task automatic t_directed();
    run_and_check("basic", 16'd10000, 16'd0, 16'd4000);
    run_and_check("R6 zero angle", 16'd8000, 16'd3000, 16'd0);
    run_and_check("R6 negative angle", 16'd9000, -16'sd2000, -16'sd9000);
    run_and_check("R7 near +pi/2", 16'd12000, 16'd0, 16'd12860);
    run_and_check("R9 small negatives", -16'sd5, -16'sd3, 16'd700);
    run_and_check("R9 negative large", -16'sd11000, -16'sd7000, -16'sd12000);
  endtask

  task automatic t_busy_ignore();
    logic signed [W-1:0] ex, ey;
    int cyc;
    ref_rot(16'd6000, 16'd5000, 16'd3000, ex, ey);
    start_op(16'd6000, 16'd5000, 16'd3000);
    repeat (40) @(negedge clk);
    check("R3 ready low mid-run", 32'(in_ready), 32'd0);
    in_valid = 1'b1; in_x = 16'd1; in_y = 16'd2; in_z = -16'sd5000;
    repeat (3) @(negedge clk);
    in_valid = 1'b0;
    wait_done(cyc);
    check("R3 latency unaffected", cyc + 43, W * N);
    check("R3 x unaffected", 32'(signed'(out_x)), 32'(ex));
    check("R3 y unaffected", 32'(signed'(out_y)), 32'(ey));
  endtask

  task automatic t_hold();
    logic [W-1:0] hx, hy;
    run_and_check("hold setup", 16'd7000, -16'sd4000, 16'd2500);
    hx = out_x; hy = out_y;
    in_x = 16'd123; in_y = 16'd456; in_z = 16'd789;
    repeat (30) @(negedge clk);
    check("R8 x held", 32'(out_x), 32'(hx));
    check("R8 y held", 32'(out_y), 32'(hy));
    check("R8 no done while idle", 32'(out_done), 32'd0);
  endtask

  task automatic t_random();
    for (int n = 0; n < 24; n++) begin
      int xi, yi, zi;
      xi = int'($urandom_range(24000)) - 12000;
      yi = int'($urandom_range(24000)) - 12000;
      zi = int'($urandom_range(25600)) - 12800;
      run_and_check("R5 random", W'(xi), W'(yi), W'(zi));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_directed();
    t_busy_ignore();
    t_hold();
    t_random();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule